// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two independent 16-bit count units, each stored as a low byte and a high byte. Software programs the units through a byte-wide register port. A mode register gives each unit four settings: an external gate enable, a choice between timing and event counting, and a two-bit operating mode. A control register holds a run bit and an overflow flag for each unit. In timing mode a unit advances on the machine-cycle tick input, which runs at one twelfth of the oscillator rate. In counting mode it advances on falling edges of its external count pin.

There are four operating modes. The first is a 13-bit counter, in which five low-byte bits divide ahead of the high byte. The second is a plain 16-bit counter. The third is an 8-bit counter that reloads itself from the high byte. The fourth is a split mode. In split mode unit 0 becomes two separate 8-bit counters. The second of these uses unit 1's run bit and overflow flag, and unit 1 is frozen.

Each overflow of unit 1 also produces a one-clock tick. A serial baud-rate divider can use this tick.

Top module: `dual_tmr_top`

## Requirements
- R1: After a synchronous reset, all count bytes, the mode register and the control register are zero. The `ovf0_flag`, `ovf1_flag`, `baud_tick` and `rdata` outputs are also zero.
- R2: The register addresses are: 0 = control, 1 = mode, 2 = unit 0 low, 3 = unit 0 high, 4 = unit 1 low, 5 = unit 1 high. Control bits 7..4 are unit 1 flag, unit 1 run, unit 0 flag and unit 0 run, in that order, and bits 3..0 read as zero. The mode register's upper nibble configures unit 1 and its lower nibble configures unit 0. Each nibble, from MSB to LSB, holds gate, counter-select and a two-bit mode. `rdata` shows the addressed register one clock after `addr` is applied.
- R3: Mode 01 counts the high and low bytes as one 16-bit value. An increment at FFFF wraps the value to 0000 and reports an overflow.
- R4: Mode 00 counts low-byte bits 4..0 as a prescaler that carries into the high byte. Low-byte bits 7..5 hold their value. An increment with the high byte at FF and bits 4..0 at 1F wraps both and reports an overflow.
- R5: Mode 10 increments the low byte. An increment at FF instead loads the low byte from the high byte, which holds its value, and reports an overflow.
- R6: When unit 0 is in mode 11, its low byte is an 8-bit counter under unit 0's run, gate and select bits, and its wrap sets the unit 0 flag. Its high byte counts ticks while the unit 1 run bit is set, and its wrap sets the unit 1 flag. Unit 1 keeps its count. A unit 1 configured in mode 11 also keeps its count.
- R7: A unit with gate = 0 runs while its run bit is 1. A unit with gate = 1 runs only while its run bit is 1 and its `ext_gate` pin is 1.
- R8: With select = 0 a running unit advances once per clock in which `tick` is 1. With select = 1 it advances once for each falling edge of its `ext_cnt` pin, where a falling edge is a 1 followed by a 0 in two successive clock samples, and `tick` has no effect.
- R9: An overflow sets the unit's flag. The flag stays set until a control write puts a 0 in its bit or the unit's `ack` input is 1. An overflow in the same clock wins over either clear.
- R10: `baud_tick` is 1 for one clock, one clock after each overflow of unit 1.
- R11: A write to a count byte of a unit takes priority over counting in that clock. That unit reports no overflow in that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle tick, one clock wide |
| ext_cnt | input | 2 | External event pins, bit n for unit n |
| ext_gate | input | 2 | External gate pins, bit n for unit n |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address for writes and reads |
| wdata | input | BW | Write data |
| ack0 | input | 1 | Clears the unit 0 flag |
| ack1 | input | 1 | Clears the unit 1 flag |
| rdata | output | BW | Registered read data |
| ovf0_flag | output | 1 | Unit 0 overflow flag |
| ovf1_flag | output | 1 | Unit 1 overflow flag |
| baud_tick | output | 1 | One-clock pulse per unit 1 overflow |

## Verification
The stability checks assume that the count bytes change only through counting or through a write to their own addresses. The stimulus therefore keeps writes, ticks and pin edges apart, except in one deliberate case where a write and a tick share a clock. The flag checks assume that `ack0` and control writes are single-clock events. The bench drives both in one-clock pulses, with `tick` held low during register writes. External pin edges are at least two clocks apart, so the two-sample edge detector sees every edge. The stimulus also waits for the pipeline to drain before it stops a unit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_PRE   = 2'b00,
    MD_W16   = 2'b01,
    MD_RLD   = 2'b10,
    MD_SPLIT = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      sel;
    tmr_mode_e mode;
  } unit_cfg_t;

  localparam int ADR_CTRL = 0;
  localparam int ADR_MODE = 1;
  localparam int ADR_L0   = 2;
  localparam int ADR_H0   = 3;
  localparam int ADR_L1   = 4;
  localparam int ADR_H1   = 5;

  localparam int BIT_TF1 = 7;
  localparam int BIT_TR1 = 6;
  localparam int BIT_TF0 = 5;
  localparam int BIT_TR0 = 4;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic smp_now, smp_old;
    always_ff @(posedge clk) begin
      if (rst) begin
        smp_now <= 1'b0;
        smp_old <= 1'b0;
      end else begin
        smp_now <= pin[g];
        smp_old <= smp_now;
      end
    end
    assign fall[g] = smp_old & ~smp_now;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int BW = 8,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  tmr_mode_e     mode,
  input  logic          inc_lo,
  input  logic          inc_hi,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] lo,
  output logic [BW-1:0] hi,
  output logic [1:0]    ovf
);
  localparam int CW = 2 * BW;

  logic [BW-1:0] nlo, nhi;
  logic [CW-1:0] wide;
  logic          ov_main, ov_hi;
  logic          any_wr;

  assign any_wr = wr_lo | wr_hi;
  assign wide   = {hi, lo};

  always_comb begin
    nlo     = lo;
    nhi     = hi;
    ov_main = 1'b0;
    ov_hi   = 1'b0;
    unique case (mode)
      MD_PRE: if (inc_lo) begin
        if (&lo[PW-1:0]) begin
          nlo[PW-1:0] = '0;
          nhi         = BW'(hi + 1'b1);
          ov_main     = &hi;
        end else begin
          nlo[PW-1:0] = PW'(lo[PW-1:0] + 1'b1);
        end
      end
      MD_W16: if (inc_lo) begin
        {nhi, nlo} = CW'(wide + 1'b1);
        ov_main    = &wide;
      end
      MD_RLD: if (inc_lo) begin
        if (&lo) begin
          nlo     = hi;
          ov_main = 1'b1;
        end else begin
          nlo = BW'(lo + 1'b1);
        end
      end
      MD_SPLIT: begin
        if (inc_lo) begin
          nlo     = BW'(lo + 1'b1);
          ov_main = &lo;
        end
        if (inc_hi) begin
          nhi   = BW'(hi + 1'b1);
          ov_hi = &hi;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= wr_lo ? wdata : (any_wr ? lo : nlo);
      hi <= wr_hi ? wdata : (any_wr ? hi : nhi);
    end
  end

  assign ovf = any_wr ? 2'b00 : {ov_hi, ov_main};
endmodule

// File: rtl/dual_tmr_top.sv
module dual_tmr_top
  import tmr_pkg::*;
#(
  parameter int BW = 8,
  parameter int PW = 5,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [1:0]    ext_cnt,
  input  logic [1:0]    ext_gate,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  input  logic          ack0,
  input  logic          ack1,
  output logic [BW-1:0] rdata,
  output logic          ovf0_flag,
  output logic          ovf1_flag,
  output logic          baud_tick
);
  unit_cfg_t     cfg0, cfg1;
  logic          tr0, tr1, tf0, tf1;
  logic [1:0]    fall;
  logic [BW-1:0] lo0, hi0, lo1, hi1;
  logic [1:0]    ovf0_v, ovf1_v;
  logic          wr_ctrl, wr_mode, wr_l0, wr_h0, wr_l1, wr_h1;
  logic          run0, run1, inc0, inc1, inc0_hi, split;
  logic          set0, set1, ovf1_any;
  logic [BW-1:0] rd_next;

  assign wr_ctrl = wr_en && (addr == AW'(ADR_CTRL));
  assign wr_mode = wr_en && (addr == AW'(ADR_MODE));
  assign wr_l0   = wr_en && (addr == AW'(ADR_L0));
  assign wr_h0   = wr_en && (addr == AW'(ADR_H0));
  assign wr_l1   = wr_en && (addr == AW'(ADR_L1));
  assign wr_h1   = wr_en && (addr == AW'(ADR_H1));

  tmr_edge #(.N(2)) u_edge (
    .clk (clk),
    .rst (rst),
    .pin (ext_cnt),
    .fall(fall)
  );

  assign split   = (cfg0.mode == MD_SPLIT);
  assign run0    = tr0 & (~cfg0.gate | ext_gate[0]);
  assign run1    = tr1 & (~cfg1.gate | ext_gate[1]);
  assign inc0    = run0 & (cfg0.sel ? fall[0] : tick);
  assign inc1    = run1 & (cfg1.sel ? fall[1] : tick) & ~split
                 & (cfg1.mode != MD_SPLIT);
  assign inc0_hi = split & tr1 & tick;

  tmr_core #(.BW(BW), .PW(PW)) u_unit0 (
    .clk   (clk),
    .rst   (rst),
    .mode  (cfg0.mode),
    .inc_lo(inc0),
    .inc_hi(inc0_hi),
    .wr_lo (wr_l0),
    .wr_hi (wr_h0),
    .wdata (wdata),
    .lo    (lo0),
    .hi    (hi0),
    .ovf   (ovf0_v)
  );

  tmr_core #(.BW(BW), .PW(PW)) u_unit1 (
    .clk   (clk),
    .rst   (rst),
    .mode  (cfg1.mode),
    .inc_lo(inc1),
    .inc_hi(1'b0),
    .wr_lo (wr_l1),
    .wr_hi (wr_h1),
    .wdata (wdata),
    .lo    (lo1),
    .hi    (hi1),
    .ovf   (ovf1_v)
  );

  assign ovf1_any = |ovf1_v;
  assign set0     = ovf0_v[0];
  assign set1     = split ? ovf0_v[1] : ovf1_any;

  always_comb begin
    rd_next = '0;
    case (addr)
      AW'(ADR_CTRL): begin
        rd_next[BIT_TF1] = tf1;
        rd_next[BIT_TR1] = tr1;
        rd_next[BIT_TF0] = tf0;
        rd_next[BIT_TR0] = tr0;
      end
      AW'(ADR_MODE): rd_next[7:0] = {cfg1, cfg0};
      AW'(ADR_L0):   rd_next = lo0;
      AW'(ADR_H0):   rd_next = hi0;
      AW'(ADR_L1):   rd_next = lo1;
      AW'(ADR_H1):   rd_next = hi1;
      default:       rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg0      <= '0;
      cfg1      <= '0;
      tr0       <= 1'b0;
      tr1       <= 1'b0;
      tf0       <= 1'b0;
      tf1       <= 1'b0;
      rdata     <= '0;
      baud_tick <= 1'b0;
    end else begin
      if (wr_mode) begin
        cfg0 <= unit_cfg_t'(wdata[3:0]);
        cfg1 <= unit_cfg_t'(wdata[7:4]);
      end
      if (wr_ctrl) begin
        tr0 <= wdata[BIT_TR0];
        tr1 <= wdata[BIT_TR1];
      end
      tf0 <= set0 | (wr_ctrl ? wdata[BIT_TF0] : (tf0 & ~ack0));
      tf1 <= set1 | (wr_ctrl ? wdata[BIT_TF1] : (tf1 & ~ack1));
      rdata     <= rd_next;
      baud_tick <= ovf1_any;
    end
  end

  assign ovf0_flag = tf0;
  assign ovf1_flag = tf1;
endmodule

// File: rtl/dual_tmr_chk.sv
module dual_tmr_chk #(
  parameter int BW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          ack0,
  input logic [1:0]    ext_gate,
  input logic          ovf0_flag,
  input logic          baud_tick,
  input logic [3:0]    cfg0_bits,
  input logic          tr0,
  input logic [BW-1:0] lo0,
  input logic [BW-1:0] hi0,
  input logic [BW-1:0] lo1,
  input logic [BW-1:0] hi1,
  input logic          set0,
  input logic          ovf1_any
);
  logic wr_ctrl, wr_u0, wr_u1, is_split;
  assign wr_ctrl  = wr_en && (addr == AW'(0));
  assign wr_u0    = wr_en && ((addr == AW'(2)) || (addr == AW'(3)));
  assign wr_u1    = wr_en && ((addr == AW'(4)) || (addr == AW'(5)));
  assign is_split = (cfg0_bits[1:0] == 2'b11);

  // R6: unit 1 frozen while unit 0 is split
  a_r6_unit1_frozen: assert property (@(posedge clk) disable iff (rst)
    (is_split && !wr_u1) |=> $stable({hi1, lo1}));

  // R7: gate closed stops unit 0
  a_r7_gate_blocks: assert property (@(posedge clk) disable iff (rst)
    (cfg0_bits[3] && !ext_gate[0] && !is_split && !wr_u0) |=> $stable({hi0, lo0}));

  // R7: run bit clear stops unit 0
  a_r7_stopped: assert property (@(posedge clk) disable iff (rst)
    (!tr0 && !is_split && !wr_u0) |=> $stable({hi0, lo0}));

  // R9: flag holds without a clear
  a_r9_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (ovf0_flag && !ack0 && !wr_ctrl) |=> ovf0_flag);

  // R9: acknowledge clears when no overflow competes
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack0 && !set0 && !wr_ctrl) |=> !ovf0_flag);

  // R10: baud pulse follows a unit 1 overflow
  a_r10_baud_source: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> $past(ovf1_any));
endmodule

bind dual_tmr_top dual_tmr_chk #(.BW(BW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .addr     (addr),
  .ack0     (ack0),
  .ext_gate (ext_gate),
  .ovf0_flag(ovf0_flag),
  .baud_tick(baud_tick),
  .cfg0_bits(cfg0),
  .tr0      (tr0),
  .lo0      (lo0),
  .hi0      (hi0),
  .lo1      (lo1),
  .hi1      (hi1),
  .set0     (set0),
  .ovf1_any (ovf1_any)
);

// File: tb/dual_tmr_top_test.sv
module dual_tmr_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] ext_cnt = 2'b00;
  logic [1:0] ext_gate = 2'b00;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic       ack0 = 1'b0;
  logic       ack1 = 1'b0;
  logic [7:0] rdata;
  logic       ovf0_flag, ovf1_flag, baud_tick;

  int n_cmp = 0;
  int n_bad = 0;
  int baud_cnt = 0;
  bit done = 0;

  dual_tmr_top uut (
    .clk(clk), .rst(rst), .tick(tick), .ext_cnt(ext_cnt), .ext_gate(ext_gate),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .ack0(ack0), .ack1(ack1),
    .rdata(rdata), .ovf0_flag(ovf0_flag), .ovf1_flag(ovf1_flag), .baud_tick(baud_tick)
  );

  always #2 clk = ~clk;

  always @(negedge clk) if (!rst && baud_tick) baud_cnt++;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    tick = 1'b0; wr_en = 1'b1; addr = a; wdata = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    cyc();
    d = rdata;
  endtask

  task automatic run(input int n, input int dens, output int nt);
    nt = 0;
    for (int i = 0; i < n; i++) begin
      tick = (($urandom % 100) < dens);
      if (tick) nt++;
      cyc();
    end
    tick = 1'b0;
  endtask

  function automatic void model(input logic [1:0] m, input int n,
                                inout logic [7:0] lo, inout logic [7:0] hi, inout int nov);
    for (int i = 0; i < n; i++) begin
      case (m)
        2'b00: if (lo[4:0] == 5'h1f) begin
          lo[4:0] = 5'h00;
          if (hi == 8'hff) nov++;
          hi = hi + 8'd1;
        end else lo[4:0] = lo[4:0] + 5'd1;
        2'b01: begin
          if ({hi, lo} == 16'hffff) nov++;
          {hi, lo} = {hi, lo} + 16'd1;
        end
        2'b10: if (lo == 8'hff) begin
          lo = hi; nov++;
        end else lo = lo + 8'd1;
        default: ;
      endcase
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, l0, h0, l1, h1, el0, eh0, el1, eh1;
    logic [1:0] m0, m1;
    int nt, nv0, nv1, k;
    void'($urandom(32'd1357));
    repeat (3) cyc();
    rst = 1'b0;
    cyc();

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", {8'h0, d}, 16'h0);
    end
    chk("R1 reset outputs", {13'h0, ovf0_flag, ovf1_flag, baud_tick}, 16'h0);

    // R2 register map and readback
    wr(3'd1, 8'hA5);
    rd(3'd1, d);
    chk("R2 mode readback", {8'h0, d}, 16'h00A5);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'hFF);
    rd(3'd0, d);
    chk("R2 control readback low nibble zero", {8'h0, d}, 16'h00F0);
    chk("R2 flags writable", {14'h0, ovf1_flag, ovf0_flag}, 16'h0003);
    wr(3'd0, 8'h00);

    // R3 R4 R5 R10 constrained random
    for (int it = 0; it < 14; it++) begin
      wr(3'd0, 8'h00);
      m0 = 2'($urandom % 3);
      m1 = 2'($urandom % 3);
      wr(3'd1, {2'b00, m1, 2'b00, m0});
      l0 = 8'($urandom); h0 = ($urandom % 2) ? 8'hff : 8'($urandom);
      l1 = ($urandom % 2) ? 8'hf0 | 8'($urandom % 16) : 8'($urandom);
      h1 = ($urandom % 2) ? 8'hff : 8'($urandom);
      if (m0 == 2'b10) h0 = 8'hf0 | 8'($urandom % 16);
      if (m1 == 2'b10) h1 = 8'hf8 | 8'($urandom % 8);
      wr(3'd2, l0); wr(3'd3, h0); wr(3'd4, l1); wr(3'd5, h1);
      baud_cnt = 0;
      wr(3'd0, 8'h50);
      run(50 + ($urandom % 350), 70, nt);
      el0 = l0; eh0 = h0; el1 = l1; eh1 = h1; nv0 = 0; nv1 = 0;
      model(m0, nt, el0, eh0, nv0);
      model(m1, nt, el1, eh1, nv1);
      chk($sformatf("R9 unit0 flag mode %0d", m0), {15'h0, ovf0_flag}, {15'h0, nv0 > 0});
      chk($sformatf("R9 unit1 flag mode %0d", m1), {15'h0, ovf1_flag}, {15'h0, nv1 > 0});
      wr(3'd0, 8'h00);
      rd(3'd2, l0); rd(3'd3, h0); rd(3'd4, l1); rd(3'd5, h1);
      chk($sformatf("R3 R4 R5 unit0 count mode %0d", m0), {h0, l0}, {eh0, el0});
      chk($sformatf("R3 R4 R5 unit1 count mode %0d", m1), {h1, l1}, {eh1, el1});
      chk("R10 baud pulses", 16'(baud_cnt), 16'(nv1));
    end

    // R11 write wins over counting
    wr(3'd1, 8'h11);
    wr(3'd2, 8'hff); wr(3'd3, 8'hff);
    wr(3'd0, 8'h10);
    tick = 1'b1; wr_en = 1'b1; addr = 3'd2; wdata = 8'h33;
    cyc();
    wr_en = 1'b0; tick = 1'b0;
    wr(3'd0, 8'h10);
    rd(3'd2, l0); rd(3'd3, h0);
    chk("R11 write priority", {h0, l0}, 16'hff33);
    chk("R11 no overflow on write", {15'h0, ovf0_flag}, 16'h0);

    // R9 flag set, hold, ack, write clear, set beats ack
    wr(3'd2, 8'hff); wr(3'd3, 8'hff);
    run(1, 100, nt);
    chk("R9 flag set", {15'h0, ovf0_flag}, 16'h1);
    rd(3'd0, d);
    chk("R9 control shows flag", {8'h0, d}, 16'h0030);
    repeat (8) cyc();
    chk("R9 flag holds", {15'h0, ovf0_flag}, 16'h1);
    ack0 = 1'b1; cyc(); ack0 = 1'b0;
    chk("R9 ack clears", {15'h0, ovf0_flag}, 16'h0);
    wr(3'd2, 8'hff); wr(3'd3, 8'hff);
    run(1, 100, nt);
    wr(3'd0, 8'h10);
    chk("R9 write clears", {15'h0, ovf0_flag}, 16'h0);
    wr(3'd2, 8'hff); wr(3'd3, 8'hff);
    ack0 = 1'b1; tick = 1'b1; cyc(); ack0 = 1'b0; tick = 1'b0;
    chk("R9 overflow beats ack", {15'h0, ovf0_flag}, 16'h1);
    wr(3'd0, 8'h00);

    // R6 split mode
    wr(3'd1, 8'h03);
    wr(3'd2, 8'hf0); wr(3'd3, 8'hf8); wr(3'd4, 8'h12); wr(3'd5, 8'h34);
    baud_cnt = 0;
    wr(3'd0, 8'h10);
    run(30, 100, nt);
    chk("R6 split low wrap flag0", {14'h0, ovf1_flag, ovf0_flag}, 16'h0001);
    wr(3'd0, 8'h50);
    run(20, 100, nt);
    chk("R6 split high sets flag1", {15'h0, ovf1_flag}, 16'h1);
    wr(3'd0, 8'h00);
    rd(3'd2, l0); rd(3'd3, h0); rd(3'd4, l1); rd(3'd5, h1);
    chk("R6 split low count", {8'h0, l0}, 16'h0022);
    chk("R6 split high count", {8'h0, h0}, 16'h000c);
    chk("R6 unit1 frozen", {h1, l1}, 16'h3412);
    chk("R6 no baud while frozen", 16'(baud_cnt), 16'h0);

    // R7 gating
    wr(3'd1, 8'h09);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    ext_gate = 2'b00;
    wr(3'd0, 8'h10);
    run(20, 100, nt);
    rd(3'd2, l0);
    chk("R7 gate low blocks", {8'h0, l0}, 16'h0);
    ext_gate = 2'b01;
    run(15, 100, nt);
    rd(3'd2, l0);
    chk("R7 gate high runs", {8'h0, l0}, 16'd15);
    ext_gate = 2'b00;
    wr(3'd0, 8'h00);

    // R8 event counting, tick ignored
    wr(3'd1, 8'h05);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd0, 8'h10);
    k = 5 + int'($urandom % 16);
    tick = 1'b1;
    for (int p = 0; p < k; p++) begin
      ext_cnt[0] = 1'b1; cyc(); cyc();
      ext_cnt[0] = 1'b0; cyc(); cyc();
    end
    repeat (4) cyc();
    tick = 1'b0;
    wr(3'd0, 8'h00);
    rd(3'd2, l0); rd(3'd3, h0);
    chk("R8 event count", {h0, l0}, 16'(k));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule